// File: doc/BRIEF.md
# Continuous Streaming Capture Controller

This block runs a capture channel in a free-running streaming mode. No samples are held back behind a trigger: every sample-rate tick sends one word to an outbound FIFO as soon as the host has started the stream. Host commands arrive one byte at a time. A start byte arms the stream, and a stop byte ends it and clears every error indication. Trigger matching and run-length compression play no part in this mode.

A test input replaces the live sample word with a 32-bit counter. The counter advances on each streaming tick, so a dropped word shows up on the host side as a gap in the sequence.

When a tick finds the FIFO full, the word is lost and the block latches an overrun. Two LEDs report the stream's health. The activity LED blinks slowly once words are flowing and four times faster after an overrun. The trigger LED stays lit while an overrun is latched.

Top module: `stream_capture_ctrl`

## Requirements
- R1: After reset, fifoWrEn, streamOn, ledActive and ledTrig are all 0.
- R2: A cycle with cmdValid high and cmdByte equal to 8'h10 sets streamOn on the next clock edge. Streaming then stays on until a stop command.
- R3: fifoWrEn is high for exactly one cycle, the cycle after a cycle in which sampleTick is high, streamOn is high and fifoFull is low. It is never high otherwise, including for ticks seen before streaming starts.
- R4: With testMode low, fifoWrData carries the sampleIn value present on the tick cycle, valid while fifoWrEn is high.
- R5: With testMode high, fifoWrData carries a 32-bit counter. The start command clears the counter to 0, and every tick while streaming adds 1, including ticks whose word is dropped.
- R6: A tick while streaming with fifoFull high writes nothing. It sets an overrun flag that lights ledTrig on the next edge and stays set until a stop command.
- R7: ledActive stays 0 until the first word is written. It then blinks with a period of 2^BLINK_W clock cycles.
- R8: While the overrun flag is set, ledActive blinks with a period of 2^(BLINK_W-2) cycles, a quarter of the slow period.
- R9: A cycle with cmdValid high and cmdByte equal to 8'h00 clears streamOn, the overrun flag, ledTrig and ledActive on the next edge. No word is written for a tick in that same cycle.
- R10: Command bytes other than 8'h10 and 8'h00 have no effect on streamOn, the LEDs or the writing of words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command byte valid strobe |
| cmdByte | input | 8 | Command byte from the host side |
| sampleTick | input | 1 | One-cycle sample-rate pulse |
| sampleIn | input | DATA_W | Live sampled input word |
| testMode | input | 1 | Selects the counter pattern instead of sampleIn |
| fifoFull | input | 1 | Outbound FIFO cannot take a word |
| fifoWrEn | output | 1 | FIFO write strobe |
| fifoWrData | output | DATA_W | Word written to the FIFO |
| streamOn | output | 1 | Streaming mode active |
| ledActive | output | 1 | Activity LED, blink rate shows health |
| ledTrig | output | 1 | Lit while an overrun is latched |

## Verification
The embedded assertions check three things on every cycle. Each write must follow a streaming tick that found the FIFO not full. A full FIFO at a tick must block the write and raise the trigger LED. The overrun latch must hold until a stop command, and a stop must clear the mode, the latch and the activity state. The blink periods, the data values in live and test mode, and the counter skipping past a dropped word can only be shown by the bench's scenarios. So can the fact that unknown command bytes change nothing, because each of these depends on a sequence of ticks or on measuring many cycles of LED output.

// File: rtl/scc_pkg.sv
package scc_pkg;
  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic push;   // capture the selected word and write it
    logic count;  // advance the test counter
    logic clear;  // restart the test counter at zero
  } scc_strobe_t;
endpackage

// File: rtl/scc_ctrl.sv
module scc_ctrl
  import scc_pkg::*;
#(
  parameter int          BLINK_W   = 24,
  parameter logic [7:0]  CMD_START = 8'h10,
  parameter logic [7:0]  CMD_STOP  = 8'h00
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdValid,
  input  logic [7:0]  cmdByte,
  input  logic        sampleTick,
  input  logic        fifoFull,
  output scc_strobe_t strobe,
  output logic        streamOn,
  output logic        ledActive,
  output logic        ledTrig
);
  localparam int SLOW_BIT = BLINK_W - 1;
  localparam int FAST_BIT = BLINK_W - 3;

  logic startCmd, stopCmd, overflowHit;
  logic streaming, overrun, started;
  logic [BLINK_W-1:0] presc;

  assign startCmd    = cmdValid && (cmdByte == CMD_START);
  assign stopCmd     = cmdValid && (cmdByte == CMD_STOP);
  assign overflowHit = streaming && sampleTick && fifoFull && !stopCmd;

  always_comb begin
    strobe.push  = streaming && sampleTick && !fifoFull && !stopCmd;
    strobe.count = streaming && sampleTick && !startCmd;
    strobe.clear = startCmd;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      streaming <= 1'b0;
      overrun   <= 1'b0;
      started   <= 1'b0;
      presc     <= '0;
    end else begin
      presc <= startCmd ? '0 : presc + 1'b1;
      if (stopCmd) begin
        streaming <= 1'b0;
        overrun   <= 1'b0;
        started   <= 1'b0;
      end else begin
        if (startCmd)    streaming <= 1'b1;
        if (overflowHit) overrun   <= 1'b1;
        if (strobe.push) started   <= 1'b1;
      end
    end
  end

  assign streamOn  = streaming;
  assign ledTrig   = overrun;
  assign ledActive = started && (overrun ? presc[FAST_BIT] : presc[SLOW_BIT]);

  // R6: overrun latch holds until a stop command
  a_r6_overrun_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (overrun && !stopCmd) |=> overrun);

  // R9: stop clears mode, latch and activity state
  a_r9_stop_clears: assert property (@(posedge clk) disable iff (!rstN)
    stopCmd |=> (!streaming && !overrun && !started));
endmodule

// File: rtl/scc_datapath.sv
module scc_datapath
  import scc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  scc_strobe_t       strobe,
  input  logic              testMode,
  input  logic [DATA_W-1:0] sampleIn,
  output logic              wrEn,
  output logic [DATA_W-1:0] wrData
);
  logic [DATA_W-1:0] testCnt;
  logic [DATA_W-1:0] selWord;

  assign selWord = testMode ? testCnt : sampleIn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      testCnt <= '0;
      wrEn    <= 1'b0;
      wrData  <= '0;
    end else begin
      if (strobe.clear)      testCnt <= '0;
      else if (strobe.count) testCnt <= testCnt + 1'b1;
      wrEn <= strobe.push;
      if (strobe.push) wrData <= selWord;
    end
  end

  // R3: a write strobe never lasts two cycles without a fresh push
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !strobe.push) |=> !wrEn);
endmodule

// File: rtl/stream_capture_ctrl.sv
module stream_capture_ctrl
  import scc_pkg::*;
#(
  parameter int         DATA_W    = 32,
  parameter int         BLINK_W   = 24,
  parameter logic [7:0] CMD_START = 8'h10,
  parameter logic [7:0] CMD_STOP  = 8'h00
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [7:0]        cmdByte,
  input  logic              sampleTick,
  input  logic [DATA_W-1:0] sampleIn,
  input  logic              testMode,
  input  logic              fifoFull,
  output logic              fifoWrEn,
  output logic [DATA_W-1:0] fifoWrData,
  output logic              streamOn,
  output logic              ledActive,
  output logic              ledTrig
);
  scc_strobe_t strobe;

  scc_ctrl #(
    .BLINK_W(BLINK_W), .CMD_START(CMD_START), .CMD_STOP(CMD_STOP)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdByte(cmdByte),
    .sampleTick(sampleTick), .fifoFull(fifoFull), .strobe(strobe),
    .streamOn(streamOn), .ledActive(ledActive), .ledTrig(ledTrig)
  );

  scc_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .testMode(testMode),
    .sampleIn(sampleIn), .wrEn(fifoWrEn), .wrData(fifoWrData)
  );

  // R3: every write follows a streaming tick that found room
  a_r3_write_after_tick: assert property (@(posedge clk) disable iff (!rstN)
    fifoWrEn |-> $past(sampleTick && streamOn && !fifoFull));

  // R6: a full FIFO at a streaming tick blocks the write and lights the LED
  a_r6_full_blocks: assert property (@(posedge clk) disable iff (!rstN)
    (sampleTick && streamOn && fifoFull) |=> (!fifoWrEn && ledTrig));

  // R6: the trigger LED only comes on after a tick against a full FIFO
  a_r6_trig_rise: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ledTrig) |-> $past(sampleTick && fifoFull));
endmodule

// File: tb/tb_stream_capture_ctrl.sv
`timescale 1ns/1ps
module tb_stream_capture_ctrl;
  localparam int DATA_W  = 32;
  localparam int BLINK_W = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 1'b0;
  logic [7:0] cmdByte = 8'h00;
  logic sampleTick = 1'b0;
  logic [DATA_W-1:0] sampleIn = '0;
  logic testMode = 1'b0;
  logic fifoFull = 1'b0;
  logic fifoWrEn;
  logic [DATA_W-1:0] fifoWrData;
  logic streamOn, ledActive, ledTrig;

  int nChecks = 0;
  int nFail = 0;

  always #2 clk = ~clk;

  stream_capture_ctrl #(.DATA_W(DATA_W), .BLINK_W(BLINK_W)) dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdByte(cmdByte),
    .sampleTick(sampleTick), .sampleIn(sampleIn), .testMode(testMode),
    .fifoFull(fifoFull), .fifoWrEn(fifoWrEn), .fifoWrData(fifoWrData),
    .streamOn(streamOn), .ledActive(ledActive), .ledTrig(ledTrig)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  endtask

  // one command byte for one cycle; outputs sampled at the next falling edge
  task automatic sendCmd(input logic [7:0] b);
    cmdValid = 1'b1; cmdByte = b;
    @(negedge clk);
    cmdValid = 1'b0; cmdByte = 8'h00;
  endtask

  // one tick; returns the write strobe and data seen after the edge
  task automatic doTick(input logic [31:0] d, input logic full,
                        output logic wr, output logic [31:0] dat);
    sampleTick = 1'b1; sampleIn = d; fifoFull = full;
    @(negedge clk);
    sampleTick = 1'b0; fifoFull = 1'b0;
    wr = fifoWrEn; dat = fifoWrData;
  endtask

  task automatic measurePeriod(output int per);
    int guard = 0;
    per = 0;
    while (ledActive !== 1'b0 && guard < 500) begin @(negedge clk); guard++; end
    while (ledActive !== 1'b1 && guard < 500) begin @(negedge clk); guard++; end
    while (ledActive !== 1'b0 && guard < 500) begin @(negedge clk); per++; guard++; end
    while (ledActive !== 1'b1 && guard < 500) begin @(negedge clk); per++; guard++; end
  endtask

  task automatic t_reset();
    check("R1 fifoWrEn", fifoWrEn, 0);
    check("R1 streamOn", streamOn, 0);
    check("R1 ledActive", ledActive, 0);
    check("R1 ledTrig", ledTrig, 0);
  endtask

  task automatic t_idle_tick();
    logic wr; logic [31:0] d;
    doTick(32'hAAAA_0001, 1'b0, wr, d);
    check("R3 no write before start", wr, 0);
  endtask

  task automatic t_start();
    sendCmd(8'h10);
    check("R2 streamOn after start", streamOn, 1);
    check("R7 ledActive off before first write", ledActive, 0);
    @(negedge clk);
    check("R3 no write without tick", fifoWrEn, 0);
  endtask

  task automatic t_live();
    logic wr; logic [31:0] d;
    logic [31:0] pats[4] = '{32'h0000_0000, 32'hFFFF_FFFF, 32'h1234_5678, 32'hA5A5_5A5A};
    foreach (pats[i]) begin
      doTick(pats[i], 1'b0, wr, d);
      check("R3 write on tick", wr, 1);
      check("R4 live data", d, pats[i]);
      @(negedge clk);
      check("R3 single write pulse", fifoWrEn, 0);
    end
  endtask

  task automatic t_ignored_cmd();
    logic wr; logic [31:0] d;
    sendCmd(8'h55);
    check("R10 streamOn kept", streamOn, 1);
    check("R10 ledTrig kept", ledTrig, 0);
    sendCmd(8'h01);
    doTick(32'h0BAD_F00D, 1'b0, wr, d);
    check("R10 writes continue", wr, 1);
    check("R10 data unaffected", d, 32'h0BAD_F00D);
  endtask

  task automatic t_slow_blink();
    int per;
    measurePeriod(per);
    check("R7 slow blink period", per, 1 << BLINK_W);
  endtask

  task automatic t_test_mode();
    logic wr; logic [31:0] d;
    sendCmd(8'h00);
    testMode = 1'b1;
    sendCmd(8'h10);
    for (int i = 0; i < 3; i++) begin
      doTick(32'hDEAD_BEEF, 1'b0, wr, d);
      check("R5 test write", wr, 1);
      check("R5 counter value", d, i);
    end
  endtask

  task automatic t_overrun();
    logic wr; logic [31:0] d;
    int per;
    doTick(32'h0, 1'b1, wr, d);
    check("R6 no write when full", wr, 0);
    check("R6 ledTrig on", ledTrig, 1);
    repeat (5) @(negedge clk);
    check("R6 overrun sticky", ledTrig, 1);
    doTick(32'h0, 1'b0, wr, d);
    check("R5 counter skips dropped word", d, 4);
    sendCmd(8'h10);
    check("R6 overrun kept over restart", ledTrig, 1);
    measurePeriod(per);
    check("R8 fast blink period", per, 1 << (BLINK_W - 2));
  endtask

  task automatic t_stop();
    logic wr; logic [31:0] d;
    sampleTick = 1'b1;
    sendCmd(8'h00);
    sampleTick = 1'b0;
    check("R9 no write on stop tick", fifoWrEn, 0);
    check("R9 streamOn cleared", streamOn, 0);
    check("R9 ledTrig cleared", ledTrig, 0);
    check("R9 ledActive cleared", ledActive, 0);
    doTick(32'h1, 1'b0, wr, d);
    check("R9 no write after stop", wr, 0);
    repeat (70) @(negedge clk);
    check("R9 ledActive stays off", ledActive, 0);
  endtask

  initial begin
    #(4.0 * 200000);
    nChecks++; nFail++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_idle_tick();
    t_start();
    t_live();
    t_ignored_cmd();
    t_slow_blink();
    t_test_mode();
    t_overrun();
    t_stop();
    summary();
  end
endmodule